// File: doc/BRIEF.md
# Control-Transfer Target Unit

This block sits in the execute stage of a 32-bit core. For each instruction it produces the address to fetch next. It handles unconditional and conditional PC-relative branches, absolute jumps that stay within the current 256 MB region, subroutine calls, register-indirect jumps, and the three return forms: subroutine, break and exception. A call also produces a write of the return address into the register file. An exception return also produces a strobe that restores the status word from its saved copy.

Every result is registered, so it appears one clock after the instruction is presented with `in_valid` high. When `in_valid` is low, all strobes fall on the following clock and `nxt_pc` keeps its last value. Fetch, flush control and the register file are handled outside this block.

Top module: `xfer_target_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `link_we`, `stat_we`, `nxt_pc`, `link_data`, `link_dst` and `stat_data` all become zero.
- R2: `op` is 4 bits: 0 sequential, 1 branch, 2 branch signed ≥, 3 branch signed <, 4 branch ≠, 5 branch =, 6 branch unsigned ≥, 7 branch unsigned <, 8 absolute jump, 9 call, 10 register call, 11 register jump, 12 return, 13 break return, 14 exception return, 15 next-PC read. For op 0, the next PC is `pc`+4 and no link write happens.
- R3: The unconditional branch (op 1) targets `pc` + 4 + (sign-extended `imm16` with bits 1:0 forced to zero).
- R4: Ops 2–7 compare `reg_a` with `reg_b` under the condition listed in R2. When the condition is true they take the R3 target; when it is false, the next PC is `pc`+4. They make no link write.
- R5: The absolute jump (op 8) targets {`pc`[31:28], `imm26`, 2'b00}.
- R6: A call (op 9) targets the R5 address and writes `pc`+4 to register 31.
- R7: A register call (op 10) targets `reg_a` and writes `pc`+4 to register 31.
- R8: A register jump (op 11) targets `reg_a`, a return (op 12) targets `ra_val`, and a break return (op 13) targets `ba_val`. None of them makes a link write.
- R9: An exception return (op 14) targets `ea_val`, pulses `stat_we` with `stat_data` equal to `estatus_val`, and makes no link write. `stat_we` is never high for any other op.
- R10: Next-PC read (op 15) writes `pc`+4 to register `dst_c` when `dst_c` is nonzero and makes no write when `dst_c` is zero. In both cases the next PC is `pc`+4.
- R11: Results appear one clock after `in_valid` is sampled high. A cycle with `in_valid` low drives `out_valid`, `link_we` and `stat_we` low on the next clock and leaves `nxt_pc` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| op | input | 4 | Transfer kind, encoded as in R2 |
| pc | input | 32 | Address of the current instruction |
| imm16 | input | 16 | Branch displacement |
| imm26 | input | 26 | Absolute jump word index |
| reg_a | input | 32 | First source register value |
| reg_b | input | 32 | Second source register value |
| dst_c | input | 5 | Destination register index for next-PC read |
| ra_val | input | 32 | Return-address register value |
| ea_val | input | 32 | Exception return address |
| ba_val | input | 32 | Break return address |
| estatus_val | input | 32 | Saved status word |
| out_valid | output | 1 | Registered results are valid |
| nxt_pc | output | 32 | Next fetch address |
| link_we | output | 1 | Register-file write strobe |
| link_data | output | 32 | Value to write |
| link_dst | output | 5 | Register index to write |
| stat_we | output | 1 | Status restore strobe |
| stat_data | output | 32 | Status value to restore |

## Verification
The assertions assume that `in_valid`, `op` and the operand inputs are stable across each rising edge and that `rst` is applied for at least one edge before anything is checked. The past-value checks also assume that the operand inputs are defined whenever `in_valid` is high. The bench changes inputs only on falling edges and always drives known values, including in idle cycles. The stimulus mixes directed cases with random ones: signed and unsigned operands that straddle the sign bit, equal operands, negative displacements with nonzero low bits, and a zero next-PC destination.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;

  typedef enum logic [3:0] {
    OP_SEQ    = 4'd0,
    OP_BR     = 4'd1,
    OP_BGE    = 4'd2,
    OP_BLT    = 4'd3,
    OP_BNE    = 4'd4,
    OP_BEQ    = 4'd5,
    OP_BGEU   = 4'd6,
    OP_BLTU   = 4'd7,
    OP_JABS   = 4'd8,
    OP_CALL   = 4'd9,
    OP_CALLR  = 4'd10,
    OP_JREG   = 4'd11,
    OP_RET    = 4'd12,
    OP_BRET   = 4'd13,
    OP_ERET   = 4'd14,
    OP_NEXTPC = 4'd15
  } xfer_op_e;

  typedef enum logic [2:0] {
    SRC_SEQ,
    SRC_REL,
    SRC_ABS,
    SRC_REGA,
    SRC_RA,
    SRC_BA,
    SRC_EA
  } pc_src_e;
endpackage

// File: rtl/xfer_cond.sv
module xfer_cond #(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         taken
);
  import xfer_pkg::*;

  logic eq_w, lts_w, ltu_w;

  assign eq_w  = (a == b);
  assign lts_w = ($signed(a) < $signed(b));
  assign ltu_w = (a < b);

  always_comb begin
    unique case (xfer_op_e'(op))
      OP_BR:   taken = 1'b1;
      OP_BGE:  taken = !lts_w;
      OP_BLT:  taken = lts_w;
      OP_BNE:  taken = !eq_w;
      OP_BEQ:  taken = eq_w;
      OP_BGEU: taken = !ltu_w;
      OP_BLTU: taken = ltu_w;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/xfer_addr.sv
module xfer_addr #(
  parameter int W     = 32,
  parameter int IMM_W = 16,
  parameter int KEEP  = 4
) (
  input  logic [W-1:0]        pc,
  input  logic [IMM_W-1:0]    imm16,
  input  logic [W-KEEP-3:0]   imm26,
  output logic [W-1:0]        seq_pc,
  output logic [W-1:0]        rel_pc,
  output logic [W-1:0]        abs_pc
);
  localparam int ABS_W = W - KEEP - 2;
  localparam logic [W-1:0] STEP = W'(4);

  logic [W-1:0] disp;

  assign disp   = {{(W-IMM_W){imm16[IMM_W-1]}}, imm16[IMM_W-1:2], 2'b00};
  assign seq_pc = pc + STEP;
  assign rel_pc = seq_pc + disp;

  generate
    if (KEEP > 0) begin : g_keep
      assign abs_pc = {pc[W-1 -: KEEP], imm26[ABS_W-1:0], 2'b00};
    end else begin : g_nokeep
      assign abs_pc = {imm26[ABS_W-1:0], 2'b00};
    end
  endgenerate
endmodule

// File: rtl/xfer_target_unit.sv
module xfer_target_unit #(
  parameter int W      = xfer_pkg::XLEN,
  parameter int RAW    = xfer_pkg::REG_AW,
  parameter int IMM_W  = 16,
  parameter int KEEP   = 4,
  parameter int RA_IDX = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [W-1:0]      pc,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [W-KEEP-3:0] imm26,
  input  logic [W-1:0]      reg_a,
  input  logic [W-1:0]      reg_b,
  input  logic [RAW-1:0]    dst_c,
  input  logic [W-1:0]      ra_val,
  input  logic [W-1:0]      ea_val,
  input  logic [W-1:0]      ba_val,
  input  logic [W-1:0]      estatus_val,
  output logic              out_valid,
  output logic [W-1:0]      nxt_pc,
  output logic              link_we,
  output logic [W-1:0]      link_data,
  output logic [RAW-1:0]    link_dst,
  output logic              stat_we,
  output logic [W-1:0]      stat_data
);
  import xfer_pkg::*;

  localparam logic [RAW-1:0] RA_REG = RAW'(RA_IDX);

  logic         taken_w;
  logic [W-1:0] seq_w, rel_w, abs_w;
  pc_src_e      src_w;
  logic         lw_w, sw_w;
  logic [RAW-1:0] ld_w;
  logic [W-1:0] npc_w;

  xfer_cond #(.W(W)) u_cond (
    .op(op), .a(reg_a), .b(reg_b), .taken(taken_w)
  );

  xfer_addr #(.W(W), .IMM_W(IMM_W), .KEEP(KEEP)) u_addr (
    .pc(pc), .imm16(imm16), .imm26(imm26),
    .seq_pc(seq_w), .rel_pc(rel_w), .abs_pc(abs_w)
  );

  always_comb begin
    src_w = SRC_SEQ;
    lw_w  = 1'b0;
    sw_w  = 1'b0;
    ld_w  = RA_REG;
    unique case (xfer_op_e'(op))
      OP_BR, OP_BGE, OP_BLT, OP_BNE, OP_BEQ, OP_BGEU, OP_BLTU:
        src_w = taken_w ? SRC_REL : SRC_SEQ;
      OP_JABS:  src_w = SRC_ABS;
      OP_CALL: begin
        src_w = SRC_ABS;
        lw_w  = 1'b1;
      end
      OP_CALLR: begin
        src_w = SRC_REGA;
        lw_w  = 1'b1;
      end
      OP_JREG:  src_w = SRC_REGA;
      OP_RET:   src_w = SRC_RA;
      OP_BRET:  src_w = SRC_BA;
      OP_ERET: begin
        src_w = SRC_EA;
        sw_w  = 1'b1;
      end
      OP_NEXTPC: begin
        ld_w = dst_c;
        lw_w = (dst_c != '0);
      end
      default: src_w = SRC_SEQ;
    endcase
  end

  always_comb begin
    unique case (src_w)
      SRC_REL:  npc_w = rel_w;
      SRC_ABS:  npc_w = abs_w;
      SRC_REGA: npc_w = reg_a;
      SRC_RA:   npc_w = ra_val;
      SRC_BA:   npc_w = ba_val;
      SRC_EA:   npc_w = ea_val;
      default:  npc_w = seq_w;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      link_we   <= 1'b0;
      stat_we   <= 1'b0;
      nxt_pc    <= '0;
      link_data <= '0;
      link_dst  <= '0;
      stat_data <= '0;
    end else begin
      out_valid <= in_valid;
      link_we   <= in_valid && lw_w;
      stat_we   <= in_valid && sw_w;
      if (in_valid) begin
        nxt_pc    <= npc_w;
        link_data <= seq_w;
        link_dst  <= ld_w;
        stat_data <= estatus_val;
      end
    end
  end
endmodule

// File: rtl/xfer_chk.sv
module xfer_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [3:0]  op,
  input logic [31:0] pc,
  input logic [31:0] ra_val,
  input logic [31:0] ea_val,
  input logic [31:0] estatus_val,
  input logic [4:0]  dst_c,
  input logic        out_valid,
  input logic [31:0] nxt_pc,
  input logic        link_we,
  input logic [4:0]  link_dst,
  input logic        stat_we,
  input logic [31:0] stat_data
);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !link_we && !stat_we));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd0) |=> (nxt_pc == $past(pc) + 32'd4 && !link_we));

  // R5
  abs_region_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd8) |=> (nxt_pc[31:28] == $past(pc[31:28]) && nxt_pc[1:0] == 2'b00));

  // R8
  ret_target_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd12) |=> (nxt_pc == $past(ra_val) && !link_we));

  // R9
  eret_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd14) |=> (stat_we && stat_data == $past(estatus_val) && nxt_pc == $past(ea_val)));

  // R9
  stat_only_eret_chk: assert property (@(posedge clk) disable iff (rst)
    stat_we |-> !link_we);

  // R10
  zero_dst_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd15 && dst_c == 5'd0) |=> !link_we);

  // R6
  call_link_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd9) |=> (link_we && link_dst == 5'd31));
endmodule

bind xfer_target_unit xfer_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .pc(pc),
  .ra_val(ra_val), .ea_val(ea_val), .estatus_val(estatus_val), .dst_c(dst_c),
  .out_valid(out_valid), .nxt_pc(nxt_pc), .link_we(link_we),
  .link_dst(link_dst), .stat_we(stat_we), .stat_data(stat_data)
);

// File: tb/sim_xfer_target_unit.sv
module sim_xfer_target_unit;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] pc = '0;
  logic [15:0] imm16 = '0;
  logic [25:0] imm26 = '0;
  logic [31:0] reg_a = '0, reg_b = '0;
  logic [4:0]  dst_c = '0;
  logic [31:0] ra_val = '0, ea_val = '0, ba_val = '0, estatus_val = '0;
  logic        out_valid, link_we, stat_we;
  logic [31:0] nxt_pc, link_data, stat_data;
  logic [4:0]  link_dst;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic        e_valid = 0, e_lwe = 0, e_swe = 0;
  logic [31:0] e_pc = 0, e_ld = 0, e_sd = 0;
  logic [4:0]  e_dst = 0;
  string       e_tag = "R1";

  always #(PERIOD/2) clk = ~clk;

  xfer_target_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .pc(pc),
    .imm16(imm16), .imm26(imm26), .reg_a(reg_a), .reg_b(reg_b),
    .dst_c(dst_c), .ra_val(ra_val), .ea_val(ea_val), .ba_val(ba_val),
    .estatus_val(estatus_val), .out_valid(out_valid), .nxt_pc(nxt_pc),
    .link_we(link_we), .link_data(link_data), .link_dst(link_dst),
    .stat_we(stat_we), .stat_data(stat_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd8: return "R5";
      4'd9: return "R6";
      4'd10: return "R7";
      4'd11, 4'd12, 4'd13: return "R8";
      4'd14: return "R9";
      4'd15: return "R10";
      default: return "R4";
    endcase
  endfunction

  // behavioural reference for the inputs now on the pins
  task automatic predict();
    logic [31:0] seq, rel;
    bit t;
    seq = pc + 32'd4;
    rel = seq + ({{16{imm16[15]}}, imm16} & 32'hFFFF_FFFC);
    e_tag = tag_of(op);
    if (!in_valid) begin
      e_valid = 0; e_lwe = 0; e_swe = 0; e_tag = "R11";
      return;
    end
    e_valid = 1; e_lwe = 0; e_swe = 0; e_ld = seq; e_dst = 5'd31; e_sd = estatus_val;
    case (op)
      4'd2: t = $signed(reg_a) >= $signed(reg_b);
      4'd3: t = $signed(reg_a) <  $signed(reg_b);
      4'd4: t = reg_a != reg_b;
      4'd5: t = reg_a == reg_b;
      4'd6: t = reg_a >= reg_b;
      4'd7: t = reg_a <  reg_b;
      default: t = 1;
    endcase
    case (op)
      4'd0: e_pc = seq;
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7: e_pc = t ? rel : seq;
      4'd8: e_pc = {pc[31:28], imm26, 2'b00};
      4'd9: begin e_pc = {pc[31:28], imm26, 2'b00}; e_lwe = 1; end
      4'd10: begin e_pc = reg_a; e_lwe = 1; end
      4'd11: e_pc = reg_a;
      4'd12: e_pc = ra_val;
      4'd13: e_pc = ba_val;
      4'd14: begin e_pc = ea_val; e_swe = 1; end
      default: begin e_pc = seq; e_dst = dst_c; e_lwe = (dst_c != 0); end
    endcase
  endtask

  task automatic compare();
    chk({e_tag, " valid"}, {31'd0, out_valid}, {31'd0, e_valid});
    chk({e_tag, " next pc"}, nxt_pc, e_pc);
    chk({e_tag, " link we"}, {31'd0, link_we}, {31'd0, e_lwe});
    chk({e_tag, " stat we"}, {31'd0, stat_we}, {31'd0, e_swe});
    if (e_lwe) begin
      chk({e_tag, " link data"}, link_data, e_ld);
      chk({e_tag, " link dst"}, {27'd0, link_dst}, {27'd0, e_dst});
    end
    if (e_swe) chk({e_tag, " stat data"}, stat_data, e_sd);
  endtask

  task automatic step(input bit v, input logic [3:0] o, input logic [31:0] p,
                      input logic [15:0] i16, input logic [25:0] i26,
                      input logic [31:0] a, input logic [31:0] b, input logic [4:0] c);
    in_valid = v; op = o; pc = p; imm16 = i16; imm26 = i26;
    reg_a = a; reg_b = b; dst_c = c;
    predict();
    @(negedge clk);
    compare();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    ra_val = 32'h0000_1230; ea_val = 32'h0040_0100;
    ba_val = 32'h0080_0200; estatus_val = 32'h0000_0005;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", {31'd0, out_valid}, 32'd0);
    chk("R1 next pc", nxt_pc, 32'd0);
    chk("R1 link we", {31'd0, link_we}, 32'd0);
    chk("R1 stat we", {31'd0, stat_we}, 32'd0);
    chk("R1 link data", link_data, 32'd0);
    chk("R1 stat data", stat_data, 32'd0);
    rst = 0;
    // R2 sequential
    step(1, 4'd0, 32'h1000_0000, 16'h0, 26'h0, 0, 0, 0);
    // R3 branch forward and backward with low bits set
    step(1, 4'd1, 32'h1000_0040, 16'h0013, 26'h0, 0, 0, 0);
    step(1, 4'd1, 32'h1000_0040, 16'hFFF3, 26'h0, 0, 0, 0);
    // R4 each condition taken and not taken, sign boundary
    for (int k = 2; k <= 7; k++) begin
      step(1, 4'(k), 32'h2000_0100, 16'h0020, 26'h0, 32'h8000_0000, 32'h1, 0);
      step(1, 4'(k), 32'h2000_0100, 16'h0020, 26'h0, 32'h1, 32'h8000_0000, 0);
      step(1, 4'(k), 32'h2000_0100, 16'hFFE0, 26'h0, 32'h55, 32'h55, 0);
    end
    // R5 absolute jump keeps top bits
    step(1, 4'd8, 32'hF123_4568, 16'h0, 26'h3FF_FFFF, 0, 0, 0);
    // R6 call
    step(1, 4'd9, 32'hA000_0010, 16'h0, 26'h000_0100, 0, 0, 0);
    // R7 register call
    step(1, 4'd10, 32'h0000_0800, 16'h0, 26'h0, 32'h0000_4000, 0, 0);
    // R8 jumps from registers
    step(1, 4'd11, 32'h0000_0800, 16'h0, 26'h0, 32'h0000_6000, 0, 0);
    step(1, 4'd12, 32'h0000_0800, 16'h0, 26'h0, 0, 0, 0);
    step(1, 4'd13, 32'h0000_0800, 16'h0, 26'h0, 0, 0, 0);
    // R9 exception return
    step(1, 4'd14, 32'h0000_0800, 16'h0, 26'h0, 0, 0, 0);
    // R10 nextpc, nonzero and zero destination
    step(1, 4'd15, 32'h0000_0900, 16'h0, 26'h0, 0, 0, 5'd7);
    step(1, 4'd15, 32'h0000_0900, 16'h0, 26'h0, 0, 0, 5'd0);
    // R11 idle cycle with a call on the pins: strobes low, pc held
    e_pc = nxt_pc;
    in_valid = 0; op = 4'd9; pc = 32'h1234_0000; imm26 = 26'h1;
    predict();
    e_pc = 32'h0000_0904;
    @(negedge clk);
    compare();
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] hold;
      bit v;
      hold = e_pc;
      v = ($urandom_range(0, 7) != 0);
      ra_val = $urandom; ea_val = $urandom; ba_val = $urandom; estatus_val = $urandom;
      in_valid = v; op = 4'($urandom_range(0, 15)); pc = $urandom;
      imm16 = 16'($urandom); imm26 = 26'($urandom);
      reg_a = ($urandom_range(0, 3) == 0) ? 32'h8000_0000 : $urandom;
      reg_b = ($urandom_range(0, 3) == 0) ? reg_a : $urandom;
      dst_c = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom);
      predict();
      if (!v) e_pc = hold;
      @(negedge clk);
      compare();
    end
    finish_run();
  end
endmodule